// File: doc/BRIEF.md
# Key Matrix Scanner with Serial Readout

This block walks a six-column by four-row key switch matrix one column at a time, in step with the display refresh. A column advance pulse from the display sequencer moves the active column. At each advance, the four row sense inputs for the current column go into a staging buffer. When the display cycle ends, a frame-end pulse copies the whole staging buffer, together with four discrete switch inputs, into the key RAM. The key RAM therefore always holds the matrix as it stood over one complete frame. While a display mode change is in progress, scanning is suspended.

A host reads the captured state over a three-wire serial port made of a strobe, a shift clock and a data-in line, plus a data-out line that has its own enable. The host pulls the strobe low and shifts in a command byte, least significant bit first. If the command asks for key or switch data, the block drives one bit per falling shift-clock edge, and the host samples each bit on the following rising edge. The key bytes follow each other with no gap. Raising the strobe releases the data line at once.

The serial pins are sampled by the block clock, which must run at least four times faster than the host shift clock.

Top module: `keyscan_top`

## Requirements
- R1: After reset and after every frame-end pulse, `scan_col` is one-hot on column 0. Each `col_step` pulse moves it to the next column. From column 5 it wraps to column 0. A `col_step` arriving in the same cycle as `frame_end` is ignored.
- R2: On a `col_step`, the `row_in` value is stored for the column that is active in that cycle. The key RAM changes only on a `frame_end` pulse, when it takes the stored values of all six columns.
- R3: While `mode_chg` is high, `scan_col` is all zero, and `col_step` and `frame_end` change neither the stored column values nor the key RAM nor the switch byte.
- R4: Row r of column c sits at key RAM bit 4*c + r. Byte k therefore holds column 2k in its low nibble and column 2k+1 in its high nibble.
- R5: With `stb` low, a command byte is shifted in from `sdi` on rising `sclk` edges, least significant bit first. 8'h42 selects key readout and 8'h4C selects switch readout. Any other value leaves `sdo_oe` low until `stb` rises.
- R6: In readout, `sdo` changes only after a falling `sclk` edge. The first falling edge after the eighth command bit presents bit 0 and raises `sdo_oe`, and `sdo_oe` stays high while `stb` stays low.
- R7: Key readout sends key RAM bits 0 through 23 in order with no gap at byte boundaries. After bit 23, `sdo` reads 0.
- R8: The switch byte is latched from `sw_in` at `frame_end`, with switch input n at bit n-1 and bits 7:4 zero. Switch readout sends bits 0 through 7, then zeros.
- R9: When `stb` is high, `sdo_oe` and `sdo` are 0 on the next cycle and any command in progress is abandoned.
- R10: Reading does not clear the key RAM. A second read returns the same data until the next `frame_end`.
- R11: After reset the key RAM and switch byte are zero, `scan_col` is 6'b000001, and `sdo_oe` and `sdo` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_end | input | 1 | End-of-display-cycle pulse |
| mode_chg | input | 1 | Display mode change in progress; halts scanning |
| col_step | input | 1 | Advance to the next scan column |
| row_in | input | 4 | Row sense inputs for the active column |
| sw_in | input | 4 | Discrete switch inputs 1 to 4 |
| scan_col | output | 6 | One-hot column drive |
| stb | input | 1 | Host strobe, active low |
| sclk | input | 1 | Host shift clock |
| sdi | input | 1 | Host command data |
| sdo | output | 1 | Readout data |
| sdo_oe | output | 1 | Readout data drive enable |

## Verification
Several properties are checked on every cycle: the column drive is never more than one-hot, it holds between advances, and it wraps from the last column and returns to column 0 after each frame. Readout data may change only after a falling shift clock, the drive enable stays up until the strobe rises, and the line is released after a strobe-high cycle. Other behaviour can only be shown by the bench's scenarios, which compare against a reference model on every clock. These include the bit packing, data that survives a read, staged values that appear only at a frame end, values frozen during a mode change, and zero fill after the last byte.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    localparam logic [7:0] CMD_READ_KEYS = 8'h42;
    localparam logic [7:0] CMD_READ_SW   = 8'h4C;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_KEY  = 2'd1,
        PH_SW   = 2'd2,
        PH_IDLE = 2'd3
    } phase_e;

endpackage

// File: rtl/keyscan_matrix.sv
module keyscan_matrix #(
    parameter int NCOL = 6,
    parameter int NROW = 4,
    parameter int NSW  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_end,
    input  logic                   mode_chg,
    input  logic                   col_step,
    input  logic [NROW-1:0]        row_in,
    input  logic [NSW-1:0]         sw_in,
    output logic [NCOL-1:0]        scan_col,
    output logic [NCOL*NROW-1:0]   key_ram,
    output logic [7:0]             sw_byte
);
    localparam int NBIT = NCOL * NROW;
    localparam int CW   = (NCOL > 1) ? $clog2(NCOL) : 1;

    typedef struct packed {
        logic [CW-1:0]   col;
        logic [NBIT-1:0] stage;
        logic [NBIT-1:0] kram;
        logic [7:0]      swr;
    } mat_st_t;

    mat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mode_chg) begin
            st_d.col = '0;
        end else if (frame_end) begin
            st_d.kram             = st_q.stage;
            st_d.swr              = '0;
            st_d.swr[NSW-1:0]     = sw_in;
            st_d.col              = '0;
        end else if (col_step) begin
            st_d.stage[int'(st_q.col)*NROW +: NROW] = row_in;
            if (int'(st_q.col) == NCOL-1) st_d.col = '0;
            else                          st_d.col = st_q.col + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NCOL; g++) begin : g_col
        assign scan_col[g] = !mode_chg && (st_q.col == CW'(g));
    end

    assign key_ram = st_q.kram;
    assign sw_byte = st_q.swr;

endmodule

// File: rtl/keyscan_shift.sv
module keyscan_shift
    import keyscan_pkg::*;
#(
    parameter int NBIT = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stb,
    input  logic            sclk,
    input  logic            sdi,
    input  logic [NBIT-1:0] key_ram,
    input  logic [7:0]      sw_byte,
    output logic            sdo,
    output logic            sdo_oe
);
    localparam int IW = $clog2(NBIT) + 1;

    typedef struct packed {
        logic          sclk;
        phase_e        phase;
        logic [7:0]    cmd;
        logic [IW-1:0] cnt;
        logic          sdo;
        logic          oe;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   rise, fall, key_bit, sw_bit;
    logic [7:0] cmd_next;

    always_comb begin
        key_bit = 1'b0;
        for (int i = 0; i < NBIT; i++)
            if (int'(st_q.cnt) == i) key_bit = key_ram[i];
        sw_bit = 1'b0;
        for (int i = 0; i < 8; i++)
            if (int'(st_q.cnt) == i) sw_bit = sw_byte[i];
    end

    always_comb begin
        st_d      = st_q;
        st_d.sclk = sclk;
        rise      = sclk && !st_q.sclk;
        fall      = !sclk && st_q.sclk;
        cmd_next  = {sdi, st_q.cmd[7:1]};
        if (stb) begin
            st_d.phase = PH_CMD;
            st_d.cnt   = '0;
            st_d.cmd   = '0;
            st_d.oe    = 1'b0;
            st_d.sdo   = 1'b0;
        end else begin
            case (st_q.phase)
                PH_CMD: if (rise) begin
                    st_d.cmd = cmd_next;
                    st_d.cnt = st_q.cnt + IW'(1);
                    if (st_q.cnt == IW'(7)) begin
                        st_d.cnt = '0;
                        if (cmd_next == CMD_READ_KEYS)    st_d.phase = PH_KEY;
                        else if (cmd_next == CMD_READ_SW) st_d.phase = PH_SW;
                        else                              st_d.phase = PH_IDLE;
                    end
                end
                PH_KEY, PH_SW: if (fall) begin
                    st_d.oe  = 1'b1;
                    st_d.sdo = (st_q.phase == PH_KEY) ? key_bit : sw_bit;
                    if (st_q.cnt != '1) st_d.cnt = st_q.cnt + IW'(1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{sclk: 1'b0, phase: PH_CMD, cmd: '0, cnt: '0, sdo: 1'b0, oe: 1'b0};
        else        st_q <= st_d;
    end

    assign sdo    = st_q.sdo;
    assign sdo_oe = st_q.oe;

endmodule

// File: rtl/keyscan_top.sv
module keyscan_top #(
    parameter int NCOL = 6,
    parameter int NROW = 4,
    parameter int NSW  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_end,
    input  logic            mode_chg,
    input  logic            col_step,
    input  logic [NROW-1:0] row_in,
    input  logic [NSW-1:0]  sw_in,
    output logic [NCOL-1:0] scan_col,
    input  logic            stb,
    input  logic            sclk,
    input  logic            sdi,
    output logic            sdo,
    output logic            sdo_oe
);
    localparam int NBIT = NCOL * NROW;

    logic [NBIT-1:0] key_ram;
    logic [7:0]      sw_byte;

    keyscan_matrix #(.NCOL(NCOL), .NROW(NROW), .NSW(NSW)) u_matrix (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .mode_chg  (mode_chg),
        .col_step  (col_step),
        .row_in    (row_in),
        .sw_in     (sw_in),
        .scan_col  (scan_col),
        .key_ram   (key_ram),
        .sw_byte   (sw_byte)
    );

    keyscan_shift #(.NBIT(NBIT)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .sclk    (sclk),
        .sdi     (sdi),
        .key_ram (key_ram),
        .sw_byte (sw_byte),
        .sdo     (sdo),
        .sdo_oe  (sdo_oe)
    );

endmodule

// File: rtl/keyscan_checker.sv
module keyscan_checker #(
    parameter int NCOL = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_end,
    input logic            mode_chg,
    input logic            col_step,
    input logic [NCOL-1:0] scan_col,
    input logic            stb,
    input logic            sclk,
    input logic            sdo,
    input logic            sdo_oe
);

    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scan_col));

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_step && !frame_end && !mode_chg) |=> (mode_chg || $stable(scan_col)));

    a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (col_step && !frame_end && !mode_chg && scan_col[NCOL-1]) |=> (mode_chg || scan_col[0]));

    a_r1_frame_home: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !mode_chg) |=> (mode_chg || scan_col[0]));

    a_r6_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) && $past(!stb)) |-> ($past(!sclk) && $past(sclk, 2)));

    a_r6_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && !stb) |=> sdo_oe);

    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> (!sdo_oe && !sdo));

endmodule

bind keyscan_top keyscan_checker #(.NCOL(NCOL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .mode_chg  (mode_chg),
    .col_step  (col_step),
    .scan_col  (scan_col),
    .stb       (stb),
    .sclk      (sclk),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
);

// File: tb/keyscan_top_bench.sv
module keyscan_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_end = 1'b0, mode_chg = 1'b0, col_step = 1'b0;
    logic [3:0] row_in = '0, sw_in = '0;
    logic [5:0] scan_col;
    logic       stb = 1'b1, sclk = 1'b1, sdi = 1'b0;
    logic       sdo, sdo_oe;

    int checks = 0, errors = 0, cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyscan_top u_keyscan_top (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .mode_chg(mode_chg),
        .col_step(col_step), .row_in(row_in), .sw_in(sw_in), .scan_col(scan_col),
        .stb(stb), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int  m_col;
    bit  m_stage[24];
    bit  m_kram[24];
    bit  m_sw[8];
    int  m_phase;   // 0 command, 1 keys, 2 switches, 3 ignored
    int  m_cnt;
    bit  m_cmd[8];
    bit  m_sdo, m_oe, m_psclk;

    task automatic model_reset();
        m_col = 0; m_phase = 0; m_cnt = 0; m_sdo = 0; m_oe = 0; m_psclk = 0;
        foreach (m_stage[i]) begin m_stage[i] = 0; m_kram[i] = 0; end
        foreach (m_sw[i]) m_sw[i] = 0;
        foreach (m_cmd[i]) m_cmd[i] = 0;
    endtask

    task automatic model_step();
        int code;
        if (mode_chg) m_col = 0;
        else if (frame_end) begin
            foreach (m_kram[i]) m_kram[i] = m_stage[i];
            foreach (m_sw[i]) m_sw[i] = (i < 4) ? sw_in[i] : 1'b0;
            m_col = 0;
        end else if (col_step) begin
            for (int r = 0; r < 4; r++) m_stage[m_col*4 + r] = row_in[r];
            m_col = (m_col + 1) % 6;
        end
        if (stb) begin
            m_phase = 0; m_cnt = 0; m_oe = 0; m_sdo = 0;
        end else if (m_phase == 0 && sclk && !m_psclk) begin
            m_cmd[m_cnt] = sdi;
            m_cnt++;
            if (m_cnt == 8) begin
                code = 0;
                for (int i = 0; i < 8; i++) code += int'(m_cmd[i]) << i;
                m_phase = (code == 'h42) ? 1 : (code == 'h4C) ? 2 : 3;
                m_cnt = 0;
            end
        end else if ((m_phase == 1 || m_phase == 2) && !sclk && m_psclk) begin
            m_oe = 1;
            if (m_phase == 1) m_sdo = (m_cnt < 24) ? m_kram[m_cnt] : 1'b0;
            else              m_sdo = (m_cnt < 8)  ? m_sw[m_cnt]   : 1'b0;
            m_cnt++;
        end
        m_psclk = sclk;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) model_reset();
        else        model_step();
        #1;
        if (rst_n) begin
            chk(scan_col == (mode_chg ? 6'd0 : 6'd1 << m_col), "R1/R3 scan_col", 32'(scan_col),
                32'(mode_chg ? 6'd0 : 6'd1 << m_col));
            chk(sdo_oe == m_oe, "R6/R9 sdo_oe", 32'(sdo_oe), 32'(m_oe));
            chk(sdo == m_sdo, "R7/R8 sdo", 32'(sdo), 32'(m_sdo));
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_step(input logic [3:0] rows);
        row_in = rows; col_step = 1'b1; tick(1);
        col_step = 1'b0; tick(1);
    endtask

    task automatic pulse_frame(input logic [3:0] sw);
        sw_in = sw; frame_end = 1'b1; tick(1);
        frame_end = 1'b0; tick(1);
    endtask

    task automatic send_cmd(input logic [7:0] cmd);
        stb = 1'b0; tick(2);
        for (int i = 0; i < 8; i++) begin
            sdi = cmd[i]; sclk = 1'b0; tick(2);
            sclk = 1'b1; tick(2);
        end
    endtask

    task automatic read_bits(input logic [7:0] cmd, input int n, output logic [31:0] got, output bit oe_seen);
        got = '0; oe_seen = 0;
        send_cmd(cmd);
        for (int i = 0; i < n; i++) begin
            sclk = 1'b0; tick(3);
            got[i] = sdo;
            if (sdo_oe) oe_seen = 1;
            sclk = 1'b1; tick(2);
        end
        stb = 1'b1; tick(3);
    endtask

    function automatic logic [31:0] pack(input logic [3:0] p [6]);
        logic [31:0] v = '0;
        for (int c = 0; c < 6; c++) v[c*4 +: 4] = p[c];
        return v;
    endfunction

    initial begin
        logic [31:0] got, exp_a, exp_b;
        bit oe;
        logic [3:0] pa [6] = '{4'h1, 4'h8, 4'hA, 4'h5, 4'hF, 4'h6};
        logic [3:0] pb [6] = '{4'h3, 4'hC, 4'h0, 4'h9, 4'h4, 4'hE};
        logic [3:0] pw [6];

        tick(3);
        rst_n = 1'b1;
        tick(2);
        chk(scan_col == 6'b000001, "R11 scan_col after reset", 32'(scan_col), 32'h1);
        chk(!sdo_oe && !sdo, "R11 serial idle after reset", {sdo_oe, sdo}, 0);
        read_bits(8'h42, 24, got, oe);
        chk(got == 0, "R11 key RAM zero after reset", got, 0);

        // frame with pattern A
        for (int c = 0; c < 6; c++) pulse_step(pa[c]);
        pulse_frame(4'b1010);
        exp_a = pack(pa);
        read_bits(8'h42, 32, got, oe);
        chk(got == exp_a, "R4/R7 key readout packing and zero fill", got, exp_a);
        chk(oe, "R6 drive enable during readout", 32'(oe), 1);
        read_bits(8'h4C, 12, got, oe);
        chk(got == 32'h00A, "R8 switch byte and zero fill", got, 32'h00A);
        read_bits(8'h42, 24, got, oe);
        chk(got == exp_a, "R10 second read unchanged", got, exp_a);

        // stage pattern B without frame end
        for (int c = 0; c < 6; c++) pulse_step(pb[c]);
        read_bits(8'h42, 24, got, oe);
        chk(got == exp_a, "R2 no update before frame end", got, exp_a);
        pulse_frame(4'b0101);
        exp_b = pack(pb);
        read_bits(8'h42, 24, got, oe);
        chk(got == exp_b, "R2 update at frame end", got, exp_b);

        // mode change freezes scanning
        mode_chg = 1'b1; tick(1);
        chk(scan_col == 6'd0, "R3 column drive off", 32'(scan_col), 0);
        for (int c = 0; c < 6; c++) pulse_step(pa[c]);
        pulse_frame(4'b1111);
        mode_chg = 1'b0; tick(1);
        pulse_frame(4'b0101);
        read_bits(8'h42, 24, got, oe);
        chk(got == exp_b, "R3 stage and key RAM frozen", got, exp_b);

        // wrap: eight steps overwrite columns 0 and 1
        for (int c = 0; c < 6; c++) pw[c] = pa[c];
        pw[0] = 4'h7; pw[1] = 4'hB;
        for (int c = 0; c < 6; c++) pulse_step(pa[c]);
        pulse_step(4'h7);
        pulse_step(4'hB);
        pulse_frame(4'b0011);
        read_bits(8'h42, 24, got, oe);
        chk(got == pack(pw), "R1 column wrap from 5 to 0", got, pack(pw));

        // unknown command
        read_bits(8'h55, 16, got, oe);
        chk(!oe, "R5 unknown command keeps line released", 32'(oe), 0);

        // strobe release in the middle of a read
        send_cmd(8'h42);
        for (int i = 0; i < 5; i++) begin sclk = 1'b0; tick(3); sclk = 1'b1; tick(2); end
        chk(sdo_oe, "R6 enable held during read", 32'(sdo_oe), 1);
        stb = 1'b1; tick(2);
        chk(!sdo_oe && !sdo, "R9 release on strobe high", {sdo_oe, sdo}, 0);
        tick(4);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule